// File: doc/BRIEF.md
# Eight-Token Two-Port Semaphore Unit

This block holds a small set of hardware lock tokens that two independent agents, a left port and a right port, use to coordinate ownership of a shared resource. The tokens live in their own address space, separate from any data memory. A port reaches them by raising its semaphore select while keeping its memory enable low. It then issues either a write, which carries a request or a release in data bit 0, or a read, which returns that side's view of one token.

Each side keeps one request latch per token. A request that arrives while the other side owns the token is kept pending. When the owner releases the token, the pending request takes it over in the same clock cycle. Token state is active low: a side that owns a token reads zeros, and every other case reads ones. A read value is frozen in a per-side output latch for as long as the read stays asserted, so a slow reader sees one consistent value. A port that drives its memory enable and its semaphore select together has made an illegal access. That access is discarded and reported through a one-cycle error pulse.

All state is clocked on `clk_i`. An active-low asynchronous reset clears every request, which leaves all tokens free.

Top module: `sem_token_unit`

## Requirements
- R1: After reset every token is free. A read of any token from either side returns 9'h1FF, and both error outputs are 0.
- R2: A valid access (select 1, memory enable 0) addresses token number addr[2:0]. Address bits 14..3 have no effect on which token is touched.
- R3: A valid write (write 1) looks only at data bit 0: 0 places a request and 1 withdraws it. Data bits 8..1 are ignored. A request on a free token with no competing request gives that side ownership at the clock edge that samples the write.
- R4: Flags are active low and copied onto all nine data bits. The owning side reads 9'h000 and the other side reads 9'h1FF. The two sides never own the same token at once.
- R5: While one side owns a token, a write of 0 from the other side leaves ownership and both read values unchanged. That request is kept pending. An owner never loses a token unless it writes to it.
- R6: If the owner writes 1 while the other side has a pending request, ownership moves to the other side at that same clock edge. With no pending request, the token becomes free and reads 9'h1FF on both sides.
- R7: If a request reaches a free token in an earlier cycle than the other side's request, the earlier side owns it. If both sides request a free token in the same cycle, the left side is granted it.
- R8: A read (select 1, memory enable 0, write 0, output enable 1) captures the flag at the first clock edge where it is active. The output holds that value, even if ownership changes, until the read condition drops. While no read is held, the data output is 9'h1FF.
- R9: An access with select 1 and memory enable 1 on a side changes no token. That side's error output is 1 in the cycle after each such clock edge and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_sem_sel_i | input | 1 | Left semaphore select, active high |
| l_mem_en_i | input | 1 | Left memory enable; illegal together with select |
| l_we_i | input | 1 | Left write (1) / read (0) |
| l_oe_i | input | 1 | Left output enable |
| l_addr_i | input | 15 | Left address; bits 2..0 pick the token |
| l_wdata_i | input | 9 | Left write data; bit 0 used |
| l_rdata_o | output | 9 | Left held read value |
| l_err_o | output | 1 | Left illegal-access pulse |
| r_sem_sel_i | input | 1 | Right semaphore select, active high |
| r_mem_en_i | input | 1 | Right memory enable; illegal together with select |
| r_we_i | input | 1 | Right write (1) / read (0) |
| r_oe_i | input | 1 | Right output enable |
| r_addr_i | input | 15 | Right address; bits 2..0 pick the token |
| r_wdata_i | input | 9 | Right write data; bit 0 used |
| r_rdata_o | output | 9 | Right held read value |
| r_err_o | output | 1 | Right illegal-access pulse |

## Verification
The assertions assume that reset is held low before the first clock edge. They also assume that inputs change only away from the rising edge, so each access is sampled as one clean cycle. The ownership and read-hold properties make no assumption about how long an access lasts. The bench drives every input at the falling edge and separates operations with idle cycles, and it samples outputs one falling edge after the capturing edge. Requests, releases, ties, pending requests and illegal accesses are applied to every token, with varying upper address bits. The bench checks each result against its own ownership model.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
endpackage

// File: rtl/sem_port_dec.sv
module sem_port_dec #(
  parameter int ADDR_W   = 15,
  parameter int N_TOKENS = 8,
  localparam int TOK_AW  = $clog2(N_TOKENS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sel_i,
  input  logic                men_i,
  input  logic                we_i,
  input  logic                oe_i,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [N_TOKENS-1:0] wr_o,
  output logic                rd_act_o,
  output logic [TOK_AW-1:0]   idx_o,
  output logic                err_o
);
  logic acc_ok;
  logic hit;
  logic err_q;
  logic unused_hi;

  assign unused_hi = ^addr_i[ADDR_W-1:TOK_AW];
  assign idx_o     = addr_i[TOK_AW-1:0];
  assign acc_ok    = sel_i & ~men_i;
  assign hit       = 32'(idx_o) < N_TOKENS;
  assign rd_act_o  = acc_ok & oe_i & ~we_i;

  always_comb begin
    wr_o = '0;
    if (acc_ok && we_i && hit) wr_o[idx_o] = 1'b1;
  end

  // illegal combined access: discarded above, flagged one cycle later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= sel_i & men_i;
  end
  assign err_o = err_q;
endmodule

// File: rtl/sem_token_cell.sv
module sem_token_cell
  import sem_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_l_i,
  input  logic bit_l_i,
  input  logic wr_r_i,
  input  logic bit_r_i,
  output logic own_l_o,
  output logic own_r_o
);
  logic   req_l_nq, req_r_nq;  // active-low request latches
  logic   req_l_nx, req_r_nx;
  owner_e own_q, own_nx;

  assign req_l_nx = wr_l_i ? bit_l_i : req_l_nq;
  assign req_r_nx = wr_r_i ? bit_r_i : req_r_nq;

  always_comb begin
    own_nx = own_q;
    unique case (own_q)
      OWN_LEFT: begin
        if (req_l_nx) own_nx = req_r_nx ? OWN_NONE : OWN_RIGHT;
      end
      OWN_RIGHT: begin
        if (req_r_nx) own_nx = req_l_nx ? OWN_NONE : OWN_LEFT;
      end
      default: begin
        // free: left wins a same-cycle tie
        if (!req_l_nx)      own_nx = OWN_LEFT;
        else if (!req_r_nx) own_nx = OWN_RIGHT;
        else                own_nx = OWN_NONE;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_l_nq <= 1'b1;
      req_r_nq <= 1'b1;
      own_q    <= OWN_NONE;
    end else begin
      req_l_nq <= req_l_nx;
      req_r_nq <= req_r_nx;
      own_q    <= own_nx;
    end
  end

  assign own_l_o = (own_q == OWN_LEFT);
  assign own_r_o = (own_q == OWN_RIGHT);
endmodule

// File: rtl/sem_read_latch.sv
module sem_read_latch #(
  parameter int DATA_W   = 9,
  parameter int N_TOKENS = 8,
  localparam int TOK_AW  = $clog2(N_TOKENS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rd_act_i,
  input  logic [TOK_AW-1:0]   idx_i,
  input  logic [N_TOKENS-1:0] flags_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                hold_o
);
  logic hold_q;
  logic val_q;
  logic cur;

  assign cur = (32'(idx_i) < N_TOKENS) ? flags_i[idx_i] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      val_q  <= 1'b1;
    end else begin
      hold_q <= rd_act_i;
      if (rd_act_i && !hold_q) val_q <= cur;
    end
  end

  assign hold_o  = hold_q;
  assign rdata_o = hold_q ? {DATA_W{val_q}} : {DATA_W{1'b1}};
endmodule

// File: rtl/sem_token_unit.sv
module sem_token_unit #(
  parameter int ADDR_W   = 15,
  parameter int DATA_W   = 9,
  parameter int N_TOKENS = 8,
  localparam int TOK_AW  = $clog2(N_TOKENS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_sem_sel_i,
  input  logic              l_mem_en_i,
  input  logic              l_we_i,
  input  logic              l_oe_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  output logic [DATA_W-1:0] l_rdata_o,
  output logic              l_err_o,
  input  logic              r_sem_sel_i,
  input  logic              r_mem_en_i,
  input  logic              r_we_i,
  input  logic              r_oe_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  output logic [DATA_W-1:0] r_rdata_o,
  output logic              r_err_o
);
  logic [N_TOKENS-1:0] l_wr, r_wr;
  logic [N_TOKENS-1:0] own_l, own_r;
  logic                l_rd_act, r_rd_act;
  logic [TOK_AW-1:0]   l_idx, r_idx;
  logic                l_hold, r_hold;
  logic                l_wr_any, r_wr_any;
  logic                unused_wd;

  assign unused_wd = ^{l_wdata_i[DATA_W-1:1], r_wdata_i[DATA_W-1:1]};
  assign l_wr_any  = |l_wr;
  assign r_wr_any  = |r_wr;

  sem_port_dec #(.ADDR_W(ADDR_W), .N_TOKENS(N_TOKENS)) i_dec_l (
    .clk_i, .rst_ni,
    .sel_i(l_sem_sel_i), .men_i(l_mem_en_i), .we_i(l_we_i), .oe_i(l_oe_i),
    .addr_i(l_addr_i), .wr_o(l_wr), .rd_act_o(l_rd_act), .idx_o(l_idx),
    .err_o(l_err_o)
  );

  sem_port_dec #(.ADDR_W(ADDR_W), .N_TOKENS(N_TOKENS)) i_dec_r (
    .clk_i, .rst_ni,
    .sel_i(r_sem_sel_i), .men_i(r_mem_en_i), .we_i(r_we_i), .oe_i(r_oe_i),
    .addr_i(r_addr_i), .wr_o(r_wr), .rd_act_o(r_rd_act), .idx_o(r_idx),
    .err_o(r_err_o)
  );

  for (genvar t = 0; t < N_TOKENS; t++) begin : g_tok
    sem_token_cell i_cell (
      .clk_i, .rst_ni,
      .wr_l_i(l_wr[t]), .bit_l_i(l_wdata_i[0]),
      .wr_r_i(r_wr[t]), .bit_r_i(r_wdata_i[0]),
      .own_l_o(own_l[t]), .own_r_o(own_r[t])
    );
  end

  sem_read_latch #(.DATA_W(DATA_W), .N_TOKENS(N_TOKENS)) i_rd_l (
    .clk_i, .rst_ni, .rd_act_i(l_rd_act), .idx_i(l_idx),
    .flags_i(~own_l), .rdata_o(l_rdata_o), .hold_o(l_hold)
  );

  sem_read_latch #(.DATA_W(DATA_W), .N_TOKENS(N_TOKENS)) i_rd_r (
    .clk_i, .rst_ni, .rd_act_i(r_rd_act), .idx_i(r_idx),
    .flags_i(~own_r), .rdata_o(r_rdata_o), .hold_o(r_hold)
  );
endmodule

// File: rtl/sem_token_unit_chk.sv
module sem_token_unit_chk #(
  parameter int DATA_W   = 9,
  parameter int N_TOKENS = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                l_sem_sel_i,
  input logic                l_mem_en_i,
  input logic                r_sem_sel_i,
  input logic                r_mem_en_i,
  input logic                l_err_o,
  input logic                r_err_o,
  input logic [N_TOKENS-1:0] own_l,
  input logic [N_TOKENS-1:0] own_r,
  input logic                l_wr_any,
  input logic                r_wr_any,
  input logic                l_hold,
  input logic                r_hold,
  input logic [DATA_W-1:0]   l_rdata_o,
  input logic [DATA_W-1:0]   r_rdata_o
);
  p_mutex_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_l & own_r) == '0);

  p_keep_left_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !l_wr_any |=> ((own_l & $past(own_l)) == $past(own_l)));

  p_keep_right_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !r_wr_any |=> ((own_r & $past(own_r)) == $past(own_r)));

  p_hold_left_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_hold && $past(l_hold)) |-> $stable(l_rdata_o));

  p_hold_right_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_hold && $past(r_hold)) |-> $stable(r_rdata_o));

  p_err_left_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_sem_sel_i && l_mem_en_i) |=> l_err_o);

  p_err_right_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_sem_sel_i && r_mem_en_i) |=> r_err_o);

  p_noop_left_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_sem_sel_i && l_mem_en_i && !r_wr_any) |=> ($stable(own_l) && $stable(own_r)));
endmodule

bind sem_token_unit sem_token_unit_chk #(.DATA_W(DATA_W), .N_TOKENS(N_TOKENS)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .l_sem_sel_i(l_sem_sel_i), .l_mem_en_i(l_mem_en_i),
  .r_sem_sel_i(r_sem_sel_i), .r_mem_en_i(r_mem_en_i),
  .l_err_o(l_err_o), .r_err_o(r_err_o),
  .own_l(own_l), .own_r(own_r),
  .l_wr_any(l_wr_any), .r_wr_any(r_wr_any),
  .l_hold(l_hold), .r_hold(r_hold),
  .l_rdata_o(l_rdata_o), .r_rdata_o(r_rdata_o)
);

// File: tb/test_sem_token_unit.sv
module test_sem_token_unit;
  localparam int NT = 8;
  localparam int AW = 15;
  localparam int DW = 9;
  localparam logic [DW-1:0] ONES = '1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_ni;
  logic          l_sel, l_men, l_we, l_oe, r_sel, r_men, r_we, r_oe;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wd, r_wd;
  logic [DW-1:0] l_rd, r_rd;
  logic          l_err, r_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  int m_own[NT];  // 0 free, 1 left, 2 right
  bit m_rl[NT];   // 1 = no request
  bit m_rr[NT];

  sem_token_unit i_sem_token_unit (
    .clk_i(clk), .rst_ni(rst_ni),
    .l_sem_sel_i(l_sel), .l_mem_en_i(l_men), .l_we_i(l_we), .l_oe_i(l_oe),
    .l_addr_i(l_addr), .l_wdata_i(l_wd), .l_rdata_o(l_rd), .l_err_o(l_err),
    .r_sem_sel_i(r_sel), .r_mem_en_i(r_men), .r_we_i(r_we), .r_oe_i(r_oe),
    .r_addr_i(r_addr), .r_wdata_i(r_wd), .r_rdata_o(r_rd), .r_err_o(r_err)
  );

  task automatic chk(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle();
    {l_sel, l_men, l_we, l_oe, r_sel, r_men, r_we, r_oe} = '0;
    l_addr = '0; r_addr = '0; l_wd = '0; r_wd = '0;
  endtask

  function automatic logic [AW-1:0] mk_addr(int t, logic [11:0] hi);
    return {hi, 3'(t)};
  endfunction

  function automatic void m_write(bit wl, int tl, bit bl, bit wr, int tr, bit br);
    if (wl) m_rl[tl] = bl;
    if (wr) m_rr[tr] = br;
    for (int t = 0; t < NT; t++) begin
      case (m_own[t])
        1: if (m_rl[t]) m_own[t] = m_rr[t] ? 0 : 2;
        2: if (m_rr[t]) m_own[t] = m_rl[t] ? 0 : 1;
        default: m_own[t] = !m_rl[t] ? 1 : (!m_rr[t] ? 2 : 0);
      endcase
    end
  endfunction

  function automatic logic [DW-1:0] exp_flag(int side, int t);
    return (m_own[t] == side) ? '0 : ONES;
  endfunction

  task automatic do_wr(bit wl, int tl, logic [DW-1:0] dl,
                       bit wr, int tr, logic [DW-1:0] dr, logic [11:0] hi);
    @(negedge clk);
    if (wl) begin l_sel = 1; l_we = 1; l_addr = mk_addr(tl, hi); l_wd = dl; end
    if (wr) begin r_sel = 1; r_we = 1; r_addr = mk_addr(tr, ~hi); r_wd = dr; end
    @(negedge clk);
    idle();
    m_write(wl, tl, dl[0], wr, tr, dr[0]);
  endtask

  task automatic do_rd(int side, int t, logic [11:0] hi, output logic [DW-1:0] v);
    @(negedge clk);
    if (side == 1) begin l_sel = 1; l_oe = 1; l_addr = mk_addr(t, hi); end
    else           begin r_sel = 1; r_oe = 1; r_addr = mk_addr(t, hi); end
    @(negedge clk);
    v = (side == 1) ? l_rd : r_rd;
    idle();
  endtask

  task automatic chk_tok(string tag, int t, logic [11:0] hi);
    logic [DW-1:0] v;
    do_rd(1, t, hi, v);
    chk($sformatf("%s left tok%0d", tag, t), v, exp_flag(1, t));
    do_rd(2, t, ~hi, v);
    chk($sformatf("%s right tok%0d", tag, t), v, exp_flag(2, t));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    idle();
    for (int t = 0; t < NT; t++) begin m_own[t] = 0; m_rl[t] = 1; m_rr[t] = 1; end
    rst_ni = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1;

    // R1 reset state
    chk("R1 l_err", {8'b0, l_err}, '0);
    chk("R1 r_err", {8'b0, r_err}, '0);
    chk("R1 idle l_rd", l_rd, ONES);
    for (int t = 0; t < NT; t++) chk_tok("R1 reset", t, 12'(t * 291));

    // R2 R3 R4 R5 R6 per token
    for (int t = 0; t < NT; t++) begin
      logic [11:0] hi = 12'(t * 517 + 3);
      do_wr(1, t, 9'h1FE, 0, 0, '0, hi);
      chk_tok("R3 R4 left takes", t, hi ^ 12'h5A5);
      chk_tok("R2 neighbour untouched", (t + 1) % NT, hi);
      do_wr(0, 0, '0, 1, t, 9'h0FE, hi);
      chk_tok("R5 right request pending", t, hi);
      do_wr(1, t, 9'h001, 0, 0, '0, hi);
      chk_tok("R6 handover to right", t, hi);
      do_wr(0, 0, '0, 1, t, 9'h1FF, hi);
      chk_tok("R6 free after release", t, hi);
      // owner rewrite of 0 keeps it, bits 8..1 ignored
      do_wr(0, 0, '0, 1, t, 9'h000, hi);
      do_wr(0, 0, '0, 1, t, 9'h1FE, ~hi);
      chk_tok("R3 right owns", t, hi);
      do_wr(0, 0, '0, 1, t, 9'h001, hi);
      chk_tok("R6 right release free", t, hi);
    end

    // R7 same-cycle tie then earlier-first
    for (int t = 0; t < NT; t++) begin
      do_wr(1, t, 9'h000, 1, t, 9'h000, 12'(t));
      chk_tok("R7 tie left wins", t, 12'(t + 9));
      do_wr(1, t, 9'h1FF, 0, 0, '0, 12'(t));
      chk_tok("R7 R6 tie loser gets it", t, 12'(t));
      do_wr(0, 0, '0, 1, t, 9'h1FF, 12'(t));
      do_wr(0, 0, '0, 1, t, 9'h000, 12'(t));
      do_wr(1, t, 9'h000, 0, 0, '0, 12'(t));
      chk_tok("R7 earlier right wins", t, 12'(t));
      do_wr(0, 0, '0, 1, t, 9'h1FF, 12'(t));
      do_wr(1, t, 9'h1FF, 0, 0, '0, 12'(t));
      chk_tok("R7 cleanup free", t, 12'(t));
    end

    // R8 read latch held across an ownership change
    do_wr(1, 5, 9'h000, 0, 0, '0, 12'h0);
    do_wr(0, 0, '0, 1, 5, 9'h000, 12'h0);
    @(negedge clk);
    r_sel = 1; r_oe = 1; r_addr = mk_addr(5, 12'hABC);
    @(negedge clk);
    chk("R8 captured right", r_rd, ONES);
    l_sel = 1; l_we = 1; l_addr = mk_addr(5, 12'h0); l_wd = 9'h001;
    @(negedge clk);
    l_sel = 0; l_we = 0; l_wd = '0;
    m_write(1, 5, 1, 0, 0, 0);
    r_addr = mk_addr(0, 12'h123);
    chk("R8 held over handover", r_rd, ONES);
    @(negedge clk);
    chk("R8 still held", r_rd, ONES);
    r_oe = 0;
    @(negedge clk);
    chk("R8 released idle", r_rd, ONES);
    idle();
    do_rd(2, 5, 12'h0, v);
    chk("R8 recapture owner", v, '0);
    // held 000 while right releases? right holds, left requests free side
    @(negedge clk);
    r_sel = 1; r_oe = 1; r_addr = mk_addr(5, 12'h7);
    @(negedge clk);
    chk("R8 hold zero", r_rd, '0);
    l_sel = 1; l_we = 1; l_addr = mk_addr(5, 12'h1); l_wd = 9'h000;
    @(negedge clk);
    l_sel = 0; l_we = 0;
    m_write(1, 5, 0, 0, 0, 0);
    chk("R8 hold zero stable", r_rd, '0);
    r_sel = 0;
    @(negedge clk);
    chk("R8 select drop idle", r_rd, ONES);
    idle();
    do_wr(0, 0, '0, 1, 5, 9'h1FF, 12'h0);
    chk_tok("R8 R6 left after release", 5, 12'h0);
    do_wr(1, 5, 9'h1FF, 0, 0, '0, 12'h0);
    chk_tok("R8 cleanup", 5, 12'h0);

    // R9 illegal access ignored with error pulse
    for (int t = 0; t < NT; t++) begin
      @(negedge clk);
      l_sel = 1; l_men = 1; l_we = 1; l_addr = mk_addr(t, 12'hF0F); l_wd = '0;
      r_sel = (t % 2 == 1); r_men = (t % 2 == 1); r_we = 1; r_addr = mk_addr(t, 12'h0);
      @(negedge clk);
      chk("R9 left err pulse", {8'b0, l_err}, 9'h001);
      chk("R9 right err", {8'b0, r_err}, {8'b0, 1'(t % 2 == 1)});
      idle();
      @(negedge clk);
      chk("R9 err one cycle", {8'b0, l_err}, '0);
      chk_tok("R9 illegal ignored", t, 12'h0);
    end
    // memory enable alone is no error
    @(negedge clk);
    l_men = 1; l_we = 1;
    @(negedge clk);
    chk("R9 mem only no err", {8'b0, l_err}, '0);
    idle();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule